// File: doc/BRIEF.md
# Instruction-Class Adaptive Clock Period Selector

This block sits beside the fetch stage of a 32-bit integer pipeline that uses the SPARC V8 instruction format. It sorts every fetched instruction into a timing-vulnerability class and moves that class tag along with the instruction. Each cycle it picks a clock-period code for an external clock generator. The code is chosen for the most delay-critical instruction that sits in the execute or memory stage.

Period codes come from a small programmable table. The table is indexed by the voltage/temperature corner that an external monitor reports and by the instruction class. A larger code means a longer, safer period. The lookup always makes a slower class at least as slow as a faster one. When the corner changes, the block holds a safe period for one cycle. The pipeline control inputs (advance, flush) come from the processor, and the table is loaded through a plain write port.

Top module: `iclass_clk_sel`

## Requirements
- R1: A valid fetch is decoded from op = bits 31:30 and op3 = bits 24:19. It is coded 2 (memory) when op = 3. It is coded 3 (multiply/divide) when op = 2 and op3 is 0x0A, 0x0B, 0x0E or 0x0F. Every other valid word is coded 1 (logic/arithmetic). A fetch with valid low enters as code 0 (bubble).
- R2: Class tags move fetch → decode → execute → memory, one stage per cycle in which advance is high. With advance and flush both low, every tag holds.
- R3: A flush turns the decode and execute tags into bubbles and leaves the memory-stage tag where it is. Flush takes priority over advance.
- R4: The period code is the table entry for the current corner and the highest class among the execute and memory tags. When both tags are bubbles, the class-1 entry is used. The code is registered and reflects the tags, corner and table as they stood before the edge.
- R5: The code for class k is the largest table entry among classes 1..k at that corner, so class 3 ≥ class 2 ≥ class 1 even when the table is loaded out of order.
- R6: A write stores the code into the entry for (write corner, write class) when write class is 1..3. A write class of 0 leaves the table unchanged. A stored value is used from the next edge on.
- R7: After reset every table entry and the output hold the all-ones (slowest) code, and all tags are bubbles.
- R8: In the cycle after the corner input differs from the corner seen at the previous edge, the output is the larger of the old-corner and new-corner codes. After that it settles to the new-corner code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid_i | input | 1 | Fetched word is valid |
| fetch_insn_i | input | 32 | Fetched instruction word |
| adv_i | input | 1 | Pipeline advances this cycle |
| flush_i | input | 1 | Flush of the front stages |
| corner_i | input | $clog2(NCORNER) | Corner code from the variability monitor |
| tbl_wr_en_i | input | 1 | Table write strobe |
| tbl_wr_corner_i | input | $clog2(NCORNER) | Corner of the entry to write |
| tbl_wr_class_i | input | 2 | Class of the entry to write (1..3) |
| tbl_wr_code_i | input | PW | Period code to store |
| period_sel_o | output | PW | Registered period-select code |

## Verification
Every pair drawn from thirteen instruction kinds is streamed through the pipeline at each of the four corners. This separates the memory, multiply/divide and logic decodes, including branch-like formats and invalid fetches. It also shows which stage a tag must reach before it changes the period. A pseudo-random run mixes stalls, flushes and valid gaps, which exposes tags that move, vanish or stay behind in the wrong cycle. A second table load puts slow classes below fast ones and checks that the ordering still holds. A walk through every corner pair with a multiply in flight checks the one-cycle guard value on each transition.

// File: rtl/iclk_pkg.sv
package iclk_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_ALU    = 2'd1,
    CLS_MEM    = 2'd2,
    CLS_MULDIV = 2'd3
  } iclass_e;

  localparam int unsigned NCLS = 3;

  localparam logic [1:0] OPF_FMT2 = 2'b10;
  localparam logic [1:0] OPF_MEM  = 2'b11;

  localparam logic [5:0] OP3_UMUL = 6'h0A;
  localparam logic [5:0] OP3_SMUL = 6'h0B;
  localparam logic [5:0] OP3_UDIV = 6'h0E;
  localparam logic [5:0] OP3_SDIV = 6'h0F;

endpackage

// File: rtl/iclass_decoder.sv
module iclass_decoder
  import iclk_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        valid_i,
  output iclass_e     cls_o
);

  logic [1:0] opf;
  logic [5:0] op3f;
  logic       is_muldiv;
  logic       unused_bits;

  assign opf         = insn_i[31:30];
  assign op3f        = insn_i[24:19];
  assign unused_bits = ^{insn_i[29:25], insn_i[18:0]};

  always_comb begin
    is_muldiv = (op3f == OP3_UMUL) || (op3f == OP3_SMUL) ||
                (op3f == OP3_UDIV) || (op3f == OP3_SDIV);
    if (!valid_i) begin
      cls_o = CLS_NONE;
    end else if (opf == OPF_MEM) begin
      cls_o = CLS_MEM;
    end else if ((opf == OPF_FMT2) && is_muldiv) begin
      cls_o = CLS_MULDIV;
    end else begin
      cls_o = CLS_ALU;
    end
  end

  // R1: a valid word never decodes to a bubble
  always_comb begin
    if (valid_i) a_valid_not_bubble_r1 : assert (cls_o != CLS_NONE);
  end

endmodule

// File: rtl/class_pipe_tracker.sv
module class_pipe_tracker
  import iclk_pkg::*;
#(
  parameter int unsigned NSTG    = 3,
  parameter int unsigned SENS_LO = 1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    adv_i,
  input  logic    flush_i,
  input  iclass_e cls_i,
  output iclass_e worst_o
);

  localparam int unsigned LAST = NSTG - 1;

  iclass_e stg_q [NSTG];
  iclass_e stg_d [NSTG];
  logic    stg_en;

  assign stg_en = adv_i | flush_i;

  always_comb begin
    if (flush_i) begin
      stg_d[0] = CLS_NONE;
    end else if (adv_i) begin
      stg_d[0] = cls_i;
    end else begin
      stg_d[0] = stg_q[0];
    end
    for (int s = 1; s < NSTG; s++) begin
      if (flush_i) begin
        stg_d[s] = (s == LAST) ? stg_q[s] : CLS_NONE;
      end else if (adv_i) begin
        stg_d[s] = stg_q[s-1];
      end else begin
        stg_d[s] = stg_q[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSTG; s++) stg_q[s] <= CLS_NONE;
    end else if (stg_en) begin
      stg_q <= stg_d;
    end
  end

  always_comb begin
    worst_o = CLS_NONE;
    for (int s = SENS_LO; s < NSTG; s++) begin
      if (stg_q[s] > worst_o) worst_o = stg_q[s];
    end
  end

  p_stall_hold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !flush_i) |=> ($stable(stg_q[0]) && $stable(stg_q[LAST])));

  p_advance_shift_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !flush_i) |=> (stg_q[LAST] == $past(stg_q[LAST-1])));

  p_flush_clear_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((stg_q[0] == CLS_NONE) && (stg_q[SENS_LO] == CLS_NONE)));

  p_flush_keep_mem_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> $stable(stg_q[LAST]));

endmodule

// File: rtl/period_table.sv
module period_table
  import iclk_pkg::*;
#(
  parameter int unsigned PW      = 4,
  parameter int unsigned NCORNER = 4,
  parameter int unsigned NRD     = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [$clog2(NCORNER)-1:0]         wr_corner_i,
  input  iclass_e                            wr_cls_i,
  input  logic [PW-1:0]                      wr_code_i,
  input  logic [NRD-1:0][$clog2(NCORNER)-1:0] rd_corner_i,
  input  iclass_e                            rd_cls_i,
  output logic [NRD-1:0][PW-1:0]             per_o
);

  localparam int unsigned NENT = NCORNER * NCLS;

  logic [PW-1:0] ent_q [NENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NENT; e++) ent_q[e] <= '1;
    end else if (wr_en_i) begin
      for (int c = 0; c < NCORNER; c++) begin
        for (int k = 0; k < NCLS; k++) begin
          if ((int'(wr_corner_i) == c) && (int'(wr_cls_i) == k + 1)) begin
            ent_q[c*NCLS+k] <= wr_code_i;
          end
        end
      end
    end
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin : lookup
        int            lim;
        logic [PW-1:0] acc;
        lim = (rd_cls_i == CLS_NONE) ? 1 : int'(rd_cls_i);
        acc = '0;
        for (int k = 0; k < NCLS; k++) begin
          if ((k < lim) && (int'(rd_corner_i[p]) < NCORNER)) begin
            if (ent_q[int'(rd_corner_i[p])*NCLS+k] > acc) begin
              acc = ent_q[int'(rd_corner_i[p])*NCLS+k];
            end
          end
        end
        per_o[p] = acc;
      end
    end
  endgenerate

endmodule

// File: rtl/iclass_clk_sel.sv
module iclass_clk_sel
  import iclk_pkg::*;
#(
  parameter int unsigned PW      = 4,
  parameter int unsigned NCORNER = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fetch_valid_i,
  input  logic [31:0]                fetch_insn_i,
  input  logic                       adv_i,
  input  logic                       flush_i,
  input  logic [$clog2(NCORNER)-1:0] corner_i,
  input  logic                       tbl_wr_en_i,
  input  logic [$clog2(NCORNER)-1:0] tbl_wr_corner_i,
  input  logic [1:0]                 tbl_wr_class_i,
  input  logic [PW-1:0]              tbl_wr_code_i,
  output logic [PW-1:0]              period_sel_o
);

  localparam int unsigned CRW = $clog2(NCORNER);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  iclass_e fetch_cls;
  iclass_e worst_cls;

  iclass_decoder u_dec (
    .insn_i  (fetch_insn_i),
    .valid_i (fetch_valid_i),
    .cls_o   (fetch_cls)
  );

  class_pipe_tracker #(
    .NSTG    (3),
    .SENS_LO (1)
  ) u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .adv_i   (adv_i),
    .flush_i (flush_i),
    .cls_i   (fetch_cls),
    .worst_o (worst_cls)
  );

  logic [CRW-1:0]          corner_q;
  logic [1:0][CRW-1:0]     rd_corner;
  logic [1:0][PW-1:0]      per_w;
  logic [PW-1:0]           period_d;
  logic [PW-1:0]           period_q;
  logic                    corner_moved;

  assign rd_corner[0] = corner_i;   // new corner
  assign rd_corner[1] = corner_q;   // corner at previous edge

  period_table #(
    .PW      (PW),
    .NCORNER (NCORNER),
    .NRD     (2)
  ) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .wr_en_i     (tbl_wr_en_i),
    .wr_corner_i (tbl_wr_corner_i),
    .wr_cls_i    (iclass_e'(tbl_wr_class_i)),
    .wr_code_i   (tbl_wr_code_i),
    .rd_corner_i (rd_corner),
    .rd_cls_i    (worst_cls),
    .per_o       (per_w)
  );

  assign corner_moved = (corner_i != corner_q);

  always_comb begin
    period_d = per_w[0];
    if (corner_moved && (per_w[1] > per_w[0])) begin
      period_d = per_w[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      corner_q <= '0;
      period_q <= '1;
    end else begin
      corner_q <= corner_i;
      period_q <= period_d;
    end
  end

  assign period_sel_o = period_q;

  p_corner_guard_r8 : assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    corner_moved |=> ((period_sel_o >= $past(per_w[0])) &&
                      (period_sel_o >= $past(per_w[1]))));

  p_steady_corner_r4 : assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !corner_moved |=> (period_sel_o == $past(per_w[0])));

endmodule

// File: tb/iclass_clk_sel_tb.sv
`timescale 1ns/1ps
module iclass_clk_sel_tb;

  localparam int PW = 4;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fv;
  logic [31:0] insn;
  logic        adv, flush;
  logic [1:0]  corner;
  logic        wr_en;
  logic [1:0]  wr_corner, wr_class;
  logic [PW-1:0] wr_code;
  logic [PW-1:0] period_sel;

  int    nvec = 0;
  int    nbad = 0;
  bit    done = 1'b0;
  string req  = "R7";

  int mt [NC][4];
  int md, me, mm, mcq;
  logic [31:0] lf = 32'h1D2C_3B4A;

  always #4 clk = ~clk;

  iclass_clk_sel #(.PW(PW), .NCORNER(NC)) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .fetch_valid_i   (fv),
    .fetch_insn_i    (insn),
    .adv_i           (adv),
    .flush_i         (flush),
    .corner_i        (corner),
    .tbl_wr_en_i     (wr_en),
    .tbl_wr_corner_i (wr_corner),
    .tbl_wr_class_i  (wr_class),
    .tbl_wr_code_i   (wr_code),
    .period_sel_o    (period_sel)
  );

  function automatic logic [31:0] mk(int op, int op3);
    logic [1:0] o; logic [5:0] o3;
    o = op[1:0]; o3 = op3[5:0];
    return {o, 5'b10101, o3, 19'h2A5C3};
  endfunction

  // kinds 0..11 valid words; 12 = invalid fetch carrying a multiply pattern
  function automatic logic [31:0] kind_word(int t);
    case (t)
      0: return mk(2, 'h00);  1: return mk(2, 'h04);
      2: return mk(2, 'h03);  3: return mk(2, 'h25);
      4: return mk(3, 'h00);  5: return mk(3, 'h04);
      6: return mk(2, 'h0A);  7: return mk(2, 'h0B);
      8: return mk(2, 'h0E);  9: return mk(2, 'h0F);
      10: return mk(0, 'h04); 11: return mk(1, 'h0A);
      default: return mk(2, 'h0A);
    endcase
  endfunction

  // class per R1 from op and op3 fields
  function automatic int mcls(logic v, logic [31:0] w);
    int op, op3;
    if (!v) return 0;
    op = int'(w[31:30]); op3 = int'(w[24:19]);
    if (op == 3) return 2;
    if (op == 2 && (op3 == 'h0A || op3 == 'h0B || op3 == 'h0E || op3 == 'h0F)) return 3;
    return 1;
  endfunction

  // R5: ordered lookup, R4: bubbles use the class-1 entry
  function automatic int mper(int c, int w);
    int lim, r;
    lim = (w == 0) ? 1 : w;
    r = 0;
    for (int k = 1; k <= lim; k++) if (mt[c][k] > r) r = mt[c][k];
    return r;
  endfunction

  task automatic check(int exp);
    nvec++;
    if (period_sel !== PW'(exp)) begin
      nbad++;
      $display("FAIL %s t=%0t period_sel got %0d expected %0d", req, $time, period_sel, exp);
    end
  endtask

  task automatic set_kind(int t);
    insn = kind_word(t);
    fv   = (t != 12);
  endtask

  task automatic step();
    int w, pn, po, ex;
    w  = (me > mm) ? me : mm;
    pn = mper(int'(corner), w);
    po = mper(mcq, w);
    ex = (int'(corner) != mcq && po > pn) ? po : pn;
    if (wr_en && wr_class != 2'd0) mt[int'(wr_corner)][int'(wr_class)] = int'(wr_code);
    if (flush) begin
      md = 0; me = 0;
    end else if (adv) begin
      mm = me; me = md; md = mcls(fv, insn);
    end
    mcq = int'(corner);
    @(posedge clk);
    #2;
    check(ex);
  endtask

  task automatic idle();
    adv = 1'b0; flush = 1'b0; fv = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(int c, int k, int v);
    wr_en = 1'b1; wr_corner = 2'(c); wr_class = 2'(k); wr_code = PW'(v);
    adv = 1'b0; flush = 1'b0;
    step();
    wr_en = 1'b0;
  endtask

  task automatic lfsr_next();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL R2 watchdog expired got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; corner = '0; insn = '0;
    wr_corner = '0; wr_class = '0; wr_code = '0;
    idle();
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R7: slowest code after reset
    req = "R7";
    check((1 << PW) - 1);
    for (int c = 0; c < NC; c++) for (int k = 0; k < 4; k++) mt[c][k] = (1 << PW) - 1;
    md = 0; me = 0; mm = 0; mcq = 0;

    // R7: defaults stay slowest with traffic in flight
    for (int i = 0; i < 6; i++) begin
      adv = 1'b1; set_kind(i % 13);
      step();
    end
    idle();

    // R6: load table; class 0 writes are ignored
    req = "R6";
    for (int c = 0; c < NC; c++) begin
      for (int k = 1; k <= 3; k++) wr(c, k, 3 * c + 2 * k - 1);
      wr(c, 0, 0);
    end
    for (int i = 0; i < 4; i++) begin adv = 1'b1; set_kind(0); step(); end

    // R1 and R4: every kind pair at every corner
    req = "R1_R4";
    for (int c = 0; c < NC; c++) begin
      corner = 2'(c);
      for (int a = 0; a < 13; a++) begin
        for (int b = 0; b < 13; b++) begin
          adv = 1'b1; set_kind(a); step();
          set_kind(b); step();
          set_kind(12); step(); step(); step();
        end
      end
    end

    // R2: random stalls and gaps
    req = "R2";
    corner = 2'd2;
    for (int i = 0; i < 800; i++) begin
      lfsr_next();
      adv = lf[3]; flush = 1'b0;
      set_kind(int'(lf[11:8]) % 13);
      step();
    end

    // R3: directed flush with a multiply in memory and a load in execute
    req = "R3";
    corner = 2'd1; flush = 1'b0; adv = 1'b1;
    set_kind(6); step();
    set_kind(4); step();
    set_kind(0); step();
    flush = 1'b1; step();
    flush = 1'b0; adv = 1'b0; step(); step();
    adv = 1'b1; set_kind(12); step(); step(); step();
    // R3: random flushes mixed with stalls
    for (int i = 0; i < 800; i++) begin
      lfsr_next();
      adv = lf[5]; flush = (lf[14:12] == 3'd0);
      set_kind(int'(lf[20:17]) % 13);
      step();
    end
    flush = 1'b0;

    // R5: table loaded with slow classes below fast ones
    req = "R5";
    for (int c = 0; c < NC; c++) begin
      wr(c, 1, 9 + c);
      wr(c, 2, 2);
      wr(c, 3, 1 + 4 * (c & 1) + 6 * (c >> 1));
    end
    for (int c = 0; c < NC; c++) begin
      corner = 2'(c);
      for (int a = 0; a < 13; a++) begin
        adv = 1'b1; set_kind(a); step();
        set_kind(12); step(); step(); step();
      end
    end

    // R8: every corner pair with a multiply and a load in flight
    req = "R8";
    for (int c = 0; c < NC; c++) begin
      for (int k = 1; k <= 3; k++) wr(c, k, (5 * c + 3 * k) % 16);
    end
    for (int c1 = 0; c1 < NC; c1++) begin
      for (int c2 = 0; c2 < NC; c2++) begin
        corner = 2'(c1);
        adv = 1'b1; set_kind(8); step();
        set_kind(5); step();
        adv = 1'b0; step();
        corner = 2'(c2); step(); step();
        adv = 1'b1; set_kind(12); step();
        corner = 2'(c1); step(); step(); step();
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule